// File: doc/BRIEF.md
# Cascadable Dual Pulse Timer

Two down-counting pulse channels that each produce a square or PWM waveform. In split mode every channel counts on its own: it runs down from its low-period reload value, wraps, toggles its pulse output, then runs down from its high-period reload value, and so on. In chained mode the two counters form one double-width counter. Channel 0 is the low half and channel 1 the high half. Both pulse outputs then carry the same wide-period waveform.

Every underflow sets a sticky per-channel flag, which software clears with a strobe. A single level interrupt line is formed from the flags and the per-channel enables. In chained mode one underflow sets both flags together, and either enable is enough to raise the request. Software can clear both flags in one cycle, so no half of the pair is left pending.

Top module: `casc_pulse_timer`

## Requirements
- R1: In split mode, while `run_i[n]`=1, channel n holds `pulse_o[n]`=0 for L+1 clocks and 1 for H+1 clocks, alternately. L is `lo_rld_i[n]` and H is `hi_rld_i[n]`. Each toggle is an underflow, which is the counter going from 0 to a reload.
- R2: While a channel is stopped, its counter holds its low reload and its pulse output is 0. Channel n is stopped when `run_i[n]`=0 in split mode, and both channels are stopped when `run_i[0]`=0 in chained mode. The first period after a start or a mode change is therefore a full one.
- R3: A split-mode underflow on channel n sets only `flag_o[n]`, at the same clock edge where `pulse_o[n]` toggles.
- R4: In chained mode (`chain_i`=1), the value {ch1,ch0} counts down once per clock and `run_i[0]` alone controls it (`run_i[1]` is ignored). The low phase lasts {lo1,lo0}+1 clocks and the high phase lasts {hi1,hi0}+1 clocks, and both pulse outputs carry this waveform.
- R5: In chained mode one underflow sets both flags at the same edge.
- R6: A flag stays set until its `clr_i` bit is 1 at a clock edge. That clear affects no other flag, and `clr_i`=2'b11 clears both flags in one cycle.
- R7: If an underflow and a clear of the same flag meet at the same edge, the flag stays set.
- R8: In split mode, `irq_o` = OR over n of (`flag_o[n]` AND `irq_en_i[n]`).
- R9: In chained mode, `irq_o` = (any flag set) AND (any enable set).
- R10: After reset, `pulse_o`, `flag_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| chain_i | input | 1 | 1: the two channels form one double-width counter |
| run_i | input | 2 | per-channel run; in chained mode only bit 0 is used |
| lo_rld_i | input | 2x CW | per-channel low-period reload |
| hi_rld_i | input | 2x CW | per-channel high-period reload |
| clr_i | input | 2 | per-channel flag clear strobe |
| irq_en_i | input | 2 | per-channel interrupt enable |
| pulse_o | output | 2 | pulse outputs |
| flag_o | output | 2 | sticky underflow flags |
| irq_o | output | 1 | level interrupt request |

## Verification
The hardest case to reach is a clear strobe that lands on the very edge where the same flag is being set again. To reach it, the stimulus computes the exact underflow cycle from the reload value and raises the clear one cycle earlier. The chained carry is also hard to reach. The high half moves only after the low half has wrapped, so the chained test uses a high-half reload of 1. This forces the count through a full low-half wrap before the double-width underflow, which is expected at {1,3}+1 = 260 clocks.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic {MODE_SPLIT = 1'b0, MODE_CHAIN = 1'b1} mode_e;
  localparam int NCH = 2;
endpackage

// File: rtl/casc_chan.sv
module casc_chan #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          dec_i,
  input  logic          load_i,
  input  logic [CW-1:0] lo_rld_i,
  input  logic [CW-1:0] hi_rld_i,
  output logic          zero_o,
  output logic          ph_o
);
  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= lo_rld_i;
      ph_q  <= 1'b0;
    end else if (load_i) begin
      ph_q  <= ~ph_q;
      cnt_q <= ph_q ? lo_rld_i : hi_rld_i;
    end else if (dec_i) begin
      cnt_q <= cnt_q - 1'b1;  // wraps to all ones in chained low half
    end
  end

  assign zero_o = (cnt_q == '0);
  assign ph_o   = ph_q;
endmodule

// File: rtl/casc_flags.sv
module casc_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;  // set wins
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/casc_irq.sv
module casc_irq #(
  parameter int N = 2
) (
  input  logic         chain_i,
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);
  always_comb begin
    if (chain_i) irq_o = (|flag_i) & (|en_i);
    else         irq_o = |(flag_i & en_i);
  end
endmodule

// File: rtl/casc_pulse_timer.sv
module casc_pulse_timer
  import casc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    chain_i,
  input  logic [NCH-1:0]          run_i,
  input  logic [NCH-1:0][CW-1:0]  lo_rld_i,
  input  logic [NCH-1:0][CW-1:0]  hi_rld_i,
  input  logic [NCH-1:0]          clr_i,
  input  logic [NCH-1:0]          irq_en_i,
  output logic [NCH-1:0]          pulse_o,
  output logic [NCH-1:0]          flag_o,
  output logic                    irq_o
);
  mode_e          mode;
  logic [NCH-1:0] run_c, dec_c, load_c, zero_c, ph_c, uf_c;

  assign mode = chain_i ? MODE_CHAIN : MODE_SPLIT;

  always_comb begin
    if (mode == MODE_CHAIN) begin
      run_c  = {NCH{run_i[0]}};
      dec_c  = {zero_c[0], 1'b1};           // high half steps on low wrap
      load_c = {NCH{&zero_c}};
    end else begin
      run_c  = run_i;
      dec_c  = '1;
      load_c = zero_c;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    casc_chan #(.CW(CW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (run_c[g]),
      .dec_i    (dec_c[g]),
      .load_i   (load_c[g]),
      .lo_rld_i (lo_rld_i[g]),
      .hi_rld_i (hi_rld_i[g]),
      .zero_o   (zero_c[g]),
      .ph_o     (ph_c[g])
    );
  end

  assign uf_c    = run_c & load_c;
  assign pulse_o = ph_c;

  casc_flags #(.N(NCH)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (uf_c),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  casc_irq #(.N(NCH)) u_irq (
    .chain_i (mode == MODE_CHAIN),
    .flag_i  (flag_o),
    .en_i    (irq_en_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/casc_pulse_timer_chk.sv
module casc_pulse_timer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chain_i,
  input logic [1:0] run_i,
  input logic [1:0] clr_i,
  input logic [1:0] irq_en_i,
  input logic [1:0] pulse_o,
  input logic [1:0] flag_o,
  input logic       irq_o
);
  a_r3_flag0_on_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o[0]) |-> !$stable(pulse_o[0]));
  a_r3_flag1_on_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o[1]) |-> !$stable(pulse_o[1]));
  a_r5_chain_both_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(chain_i) && $past(run_i[0]) && !$stable(pulse_o[0])) |-> (flag_o == 2'b11));
  a_r6_flag0_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[0] && !clr_i[0]) |=> flag_o[0]);
  a_r6_flag1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o[1] && !clr_i[1]) |=> flag_o[1]);
  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i[0] |=> !pulse_o[0]);
  a_r8_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o == 2'b00) |-> !irq_o);
  a_r9_chain_any_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chain_i && flag_o != 2'b00 && irq_en_i != 2'b00) |-> irq_o);
endmodule

bind casc_pulse_timer casc_pulse_timer_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .chain_i  (chain_i),
  .run_i    (run_i),
  .clr_i    (clr_i),
  .irq_en_i (irq_en_i),
  .pulse_o  (pulse_o),
  .flag_o   (flag_o),
  .irq_o    (irq_o)
);

// File: tb/casc_pulse_timer_bench.sv
module casc_pulse_timer_bench;
  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            chain;
  logic [1:0]      run, clr, en;
  logic [1:0][7:0] lo, hi;
  logic [1:0]      pulse, flag;
  logic            irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  typedef struct { int t; bit v; string tag; } ev_t;
  ev_t q0[$];
  ev_t q1[$];
  logic [1:0] prv;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  casc_pulse_timer u_casc_pulse_timer (
    .clk_i(clk), .rst_ni(rst_n), .chain_i(chain), .run_i(run),
    .lo_rld_i(lo), .hi_rld_i(hi), .clr_i(clr), .irq_en_i(en),
    .pulse_o(pulse), .flag_o(flag), .irq_o(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // driver side: expected toggles of one channel
  task automatic push_run(input int ch, input int c0, input int lp, input int hp,
                          input int n, input string tag);
    int t = c0;
    for (int i = 0; i < n; i++) begin
      ev_t e;
      t += ((i % 2 == 0) ? lp : hp) + 1;
      e.t = t; e.v = (i % 2 == 0); e.tag = tag;
      if (ch == 0) q0.push_back(e); else q1.push_back(e);
    end
  endtask

  task automatic pop_cmp(input int ch, input bit v);
    ev_t e;
    total++;
    if ((ch == 0 && q0.size() == 0) || (ch == 1 && q1.size() == 0)) begin
      bad++;
      $display("FAIL R1 ch%0d unexpected toggle actual=%0d@%0d expected=none", ch, v, cyc);
      return;
    end
    e = (ch == 0) ? q0.pop_front() : q1.pop_front();
    if (e.t != cyc || e.v != v) begin
      bad++;
      $display("FAIL %s ch%0d toggle actual=%0d@%0d expected=%0d@%0d", e.tag, ch, v, cyc, e.v, e.t);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (pulse[0] != prv[0]) pop_cmp(0, pulse[0]);
      if (pulse[1] != prv[1]) pop_cmp(1, pulse[1]);
    end
    prv = pulse;
  end

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic clr_pulse(input logic [1:0] m);
    clr = m;
    @(negedge clk);
    clr = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int c0;
    prv = 2'b00;
    chain = 1'b0; run = 2'b00; clr = 2'b00; en = 2'b00;
    lo = '0; hi = '0;
    repeat (3) @(negedge clk);
    check("R10 pulse", pulse, 0);
    check("R10 flag", flag, 0);
    check("R10 irq", irq, 0);
    rst_n = 1'b1;

    // ch0 alone, split mode
    lo[0] = 8'd2; hi[0] = 8'd3;
    @(negedge clk);
    c0 = cyc; run = 2'b01;
    push_run(0, c0, 2, 3, 2, "R1");
    wait_cyc(c0 + 3);
    check("R3 own flag only", flag, 2'b01);
    check("R8 irq no enable", irq, 0);
    en = 2'b01; #1;
    check("R8 irq own enable", irq, 1);
    en = 2'b10; #1;
    check("R8 irq other enable", irq, 0);
    en = 2'b00;
    wait_cyc(c0 + 7);
    run = 2'b00;

    // both channels split
    lo[0] = 8'd2; hi[0] = 8'd4; lo[1] = 8'd5; hi[1] = 8'd1;
    @(negedge clk);
    c0 = cyc; run = 2'b11;
    push_run(0, c0, 2, 4, 4, "R1");
    push_run(1, c0, 5, 1, 4, "R1");
    wait_cyc(c0 + 16);
    run = 2'b00;
    check("R3 both flags", flag, 2'b11);
    clr_pulse(2'b01);
    check("R6 clear ch0 only", flag, 2'b10);

    // clear colliding with underflow on ch1
    lo[1] = 8'd3; hi[1] = 8'd3;
    @(negedge clk);
    c0 = cyc; run = 2'b10;
    push_run(1, c0, 3, 3, 2, "R1");
    wait_cyc(c0 + 3);
    clr_pulse(2'b10);
    check("R7 set beats clear", flag[1], 1);
    clr_pulse(2'b10);
    check("R6 plain clear", flag[1], 0);
    wait_cyc(c0 + 8);
    run = 2'b00;
    check("R3 ch1 flag only", flag, 2'b10);
    clr_pulse(2'b11);
    check("R6 clear both", flag, 2'b00);

    // chained mode, run_i[1] left low
    chain = 1'b1;
    lo[0] = 8'd3; lo[1] = 8'd1; hi[0] = 8'd5; hi[1] = 8'd0;
    repeat (2) @(negedge clk);
    c0 = cyc; run = 2'b01;
    push_run(0, c0, 259, 5, 2, "R4");
    push_run(1, c0, 259, 5, 2, "R4");
    wait_cyc(c0 + 260);
    check("R5 chained both flags", flag, 2'b11);
    check("R9 irq none enabled", irq, 0);
    en = 2'b10; #1;
    check("R9 irq high enable", irq, 1);
    en = 2'b01; #1;
    check("R9 irq low enable", irq, 1);
    en = 2'b00;
    clr_pulse(2'b11);
    check("R6 chained clear both", flag, 2'b00);
    wait_cyc(c0 + 266);
    run = 2'b00;
    check("R5 second chained underflow", flag, 2'b11);
    clr_pulse(2'b11);

    // mode change while stopped, then full first period
    chain = 1'b0;
    lo[0] = 8'd1; hi[0] = 8'd1;
    @(negedge clk);
    c0 = cyc; run = 2'b01;
    push_run(0, c0, 1, 1, 2, "R2");
    wait_cyc(c0 + 4);
    run = 2'b00;
    repeat (3) @(negedge clk);
    check("R2 idle low", pulse, 0);
    check("R1 ch0 all toggles seen", q0.size(), 0);
    check("R4 ch1 all toggles seen", q1.size(), 0);
    finish_run();
  end
endmodule